// File: doc/BRIEF.md
# Wishbone Data-Bus Decoder with Timeout

This block connects one Wishbone classic-cycle master to several slave ports. It decodes the master address against a base and mask for each slave, and sends the cycle and strobe only to the slave whose window matches. The selected slave's read data, acknowledge and error go straight back to the master. Both paths are combinational, so a decoded access costs no extra clock cycles compared with a slave wired directly to the master.

A cycle counter runs while a request is open and no answer has come back. When the count reaches the timeout limit, the fabric ends the cycle itself so that a stray access cannot hang the master. A build-time parameter picks how it ends the cycle. One choice is an acknowledge that returns a fixed dummy read word. The other is a bus error. The same path covers addresses that match no window and mapped slaves that never answer.

Top module: `dbus_decoder`

## Requirements
- R1: The selected slave's strobe rises in the same cycle as the master request, and its acknowledge, error and data reach the master in the same cycle, with no register on the path.
- R2: Slave i is selected when (m_adr_i & mask_i) == base_i. Only that slave sees s_cyc_o/s_stb_o. Address, write data, byte select and write enable are shared by all slaves.
- R3: When windows overlap, the slave with the lowest index is selected. With the default map, 0x2000_0010 goes to slave 2 and 0x2500_0000 goes to slave 3.
- R4: Acknowledge, error and data from slaves that are not selected have no effect on the master. With no request open, the master sees no acknowledge and no error.
- R5: If a request (cycle and strobe both high) receives no answer, the bus completes it during the TIMEOUT-th cycle of the request, counting the first cycle as 1 (default 512).
- R6: With ACK_ON_TIMEOUT=1, a timed-out access returns m_ack_o=1, m_err_o=0 and m_dat_o=DUMMY_WORD (default 0xDEADBEEF).
- R7: With ACK_ON_TIMEOUT=0, a timed-out access returns m_err_o=1 and m_ack_o=0.
- R8: A synthetic completion lasts one cycle. The wait count clears whenever the strobe drops or an answer is returned, and it starts again from zero for the next request.
- R9: An address that matches no window asserts no slave strobe, so write data is discarded. The access ends only through the timeout.
- R10: While in reset, and with no request open, every slave strobe and every master response is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_cyc_i | input | 1 | Master cycle |
| m_stb_i | input | 1 | Master strobe |
| m_we_i | input | 1 | Master write enable |
| m_adr_i | input | AW | Master byte address |
| m_dat_i | input | DW | Master write data |
| m_sel_i | input | DW/8 | Master byte select |
| m_dat_o | output | DW | Read data to master |
| m_ack_o | output | 1 | Acknowledge to master |
| m_err_o | output | 1 | Error to master |
| s_cyc_o | output | N_SLV | Per-slave cycle |
| s_stb_o | output | N_SLV | Per-slave strobe |
| s_we_o | output | 1 | Shared write enable |
| s_adr_o | output | AW | Shared address |
| s_dat_o | output | DW | Shared write data |
| s_sel_o | output | DW/8 | Shared byte select |
| s_dat_i | input | N_SLV*DW | Read data, slave i in bits [i*DW +: DW] |
| s_ack_i | input | N_SLV | Per-slave acknowledge |
| s_err_i | input | N_SLV | Per-slave error |

## Verification
The only state in the block is the wait counter. A fault in it shows up at the master port as a completion that comes early, late, never, or lasts longer than one cycle. The bench counts the exact cycle on which the synthetic completion appears, including after a request that was dropped partway and then raised again. Decode and steering faults show up in the same cycle as the request, as a wrong strobe pattern or a leaked response from a slave that is not selected.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SLV  = 2'd1,
    SRC_TO   = 2'd2
  } resp_src_e;
endpackage

// File: rtl/dbus_addr_match.sv
module dbus_addr_match #(
  parameter int unsigned N_SLV = 4,
  parameter int unsigned AW    = 32,
  parameter logic [N_SLV*AW-1:0] SLV_BASE = '0,
  parameter logic [N_SLV*AW-1:0] SLV_MASK = '0
) (
  input  logic [AW-1:0]    adr_i,
  output logic [N_SLV-1:0] sel_o
);
  logic [N_SLV-1:0] hit;

  for (genvar i = 0; i < N_SLV; i++) begin : g_win
    assign hit[i] = (adr_i & SLV_MASK[i*AW +: AW]) == SLV_BASE[i*AW +: AW];
  end

  // lowest index wins on overlap
  always_comb begin
    logic found;
    found = 1'b0;
    sel_o = '0;
    for (int i = 0; i < N_SLV; i++) begin
      if (hit[i] && !found) begin
        sel_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbus_resp_mux.sv
module dbus_resp_mux #(
  parameter int unsigned N_SLV = 4,
  parameter int unsigned DW    = 32
) (
  input  logic [N_SLV-1:0]    gnt_i,
  input  logic [N_SLV*DW-1:0] s_dat_i,
  input  logic [N_SLV-1:0]    s_ack_i,
  input  logic [N_SLV-1:0]    s_err_i,
  output logic [DW-1:0]       dat_o,
  output logic                ack_o,
  output logic                err_o
);
  always_comb begin
    dat_o = '0;
    for (int i = 0; i < N_SLV; i++) begin
      dat_o |= s_dat_i[i*DW +: DW] & {DW{gnt_i[i]}};
    end
  end
  assign ack_o = |(s_ack_i & gnt_i);
  assign err_o = |(s_err_i & gnt_i);
endmodule

// File: rtl/dbus_timeout.sv
module dbus_timeout #(
  parameter int unsigned TIMEOUT = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic done_i,
  output logic fire_o
);
  localparam int unsigned CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  assign fire_o = busy_i && !done_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!busy_i || done_i || fire_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dbus_decoder.sv
module dbus_decoder
  import dbus_pkg::*;
#(
  parameter int unsigned N_SLV   = 4,
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned TIMEOUT = 512,
  parameter bit          ACK_ON_TIMEOUT = 1'b1,
  parameter logic [DW-1:0] DUMMY_WORD = 32'hDEAD_BEEF,
  parameter logic [N_SLV*AW-1:0] SLV_BASE =
    {32'h2000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [N_SLV*AW-1:0] SLV_MASK =
    {32'hF000_0000, 32'hFFFF_0000, 32'hFFFF_0000, 32'hFFFF_0000}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                m_cyc_i,
  input  logic                m_stb_i,
  input  logic                m_we_i,
  input  logic [AW-1:0]       m_adr_i,
  input  logic [DW-1:0]       m_dat_i,
  input  logic [DW/8-1:0]     m_sel_i,
  output logic [DW-1:0]       m_dat_o,
  output logic                m_ack_o,
  output logic                m_err_o,
  output logic [N_SLV-1:0]    s_cyc_o,
  output logic [N_SLV-1:0]    s_stb_o,
  output logic                s_we_o,
  output logic [AW-1:0]       s_adr_o,
  output logic [DW-1:0]       s_dat_o,
  output logic [DW/8-1:0]     s_sel_o,
  input  logic [N_SLV*DW-1:0] s_dat_i,
  input  logic [N_SLV-1:0]    s_ack_i,
  input  logic [N_SLV-1:0]    s_err_i
);
  logic             req;
  logic [N_SLV-1:0] sel, gnt;
  logic [DW-1:0]    slv_dat;
  logic             slv_ack, slv_err, to_fire;
  resp_src_e        src;

  assign req = m_cyc_i && m_stb_i;

  dbus_addr_match #(
    .N_SLV(N_SLV), .AW(AW), .SLV_BASE(SLV_BASE), .SLV_MASK(SLV_MASK)
  ) u_match (
    .adr_i(m_adr_i),
    .sel_o(sel)
  );

  assign gnt     = sel & {N_SLV{req}};
  assign s_cyc_o = sel & {N_SLV{m_cyc_i}};
  assign s_stb_o = gnt;
  assign s_we_o  = m_we_i;
  assign s_adr_o = m_adr_i;
  assign s_dat_o = m_dat_i;
  assign s_sel_o = m_sel_i;

  dbus_resp_mux #(.N_SLV(N_SLV), .DW(DW)) u_mux (
    .gnt_i  (gnt),
    .s_dat_i(s_dat_i),
    .s_ack_i(s_ack_i),
    .s_err_i(s_err_i),
    .dat_o  (slv_dat),
    .ack_o  (slv_ack),
    .err_o  (slv_err)
  );

  dbus_timeout #(.TIMEOUT(TIMEOUT)) u_to (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(req),
    .done_i(slv_ack || slv_err),
    .fire_o(to_fire)
  );

  always_comb begin
    if (to_fire)       src = SRC_TO;
    else if (|gnt)     src = SRC_SLV;
    else               src = SRC_NONE;
  end

  always_comb begin
    m_dat_o = slv_dat;
    m_ack_o = slv_ack;
    m_err_o = slv_err;
    if (src == SRC_TO) begin
      if (ACK_ON_TIMEOUT) begin
        m_ack_o = 1'b1;
        m_dat_o = DUMMY_WORD;
      end else begin
        m_err_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbus_decoder_chk.sv
module dbus_decoder_chk #(
  parameter int unsigned N_SLV   = 4,
  parameter int unsigned DW      = 32,
  parameter int unsigned TIMEOUT = 512,
  parameter bit          ACK_ON_TIMEOUT = 1'b1,
  parameter logic [DW-1:0] DUMMY_WORD = 32'hDEAD_BEEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             m_cyc_i,
  input logic             m_stb_i,
  input logic [DW-1:0]    m_dat_o,
  input logic             m_ack_o,
  input logic             m_err_o,
  input logic [N_SLV-1:0] s_stb_o,
  input logic [N_SLV-1:0] s_ack_i,
  input logic [N_SLV-1:0] s_err_i
);
  localparam int unsigned WW = $clog2(TIMEOUT) + 1;

  logic          req, s_ans, synth;
  logic [WW-1:0] wait_q;

  assign req   = m_cyc_i && m_stb_i;
  assign s_ans = |((s_ack_i | s_err_i) & s_stb_o);
  assign synth = (m_ack_o || m_err_o) && !s_ans;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           wait_q <= '0;
    else if (req && !m_ack_o && !m_err_o)  wait_q <= wait_q + 1'b1;
    else                                   wait_q <= '0;
  end

  p_onehot_stb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_stb_o));

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req |-> (s_stb_o == '0 && !m_ack_o && !m_err_o));

  p_timeout_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q < WW'(TIMEOUT));

  p_synth_kind_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    synth |-> (ACK_ON_TIMEOUT ? (m_ack_o && !m_err_o && m_dat_o == DUMMY_WORD)
                              : (m_err_o && !m_ack_o)));

  p_synth_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    synth |=> !synth);
endmodule

bind dbus_decoder dbus_decoder_chk #(
  .N_SLV(N_SLV), .DW(DW), .TIMEOUT(TIMEOUT),
  .ACK_ON_TIMEOUT(ACK_ON_TIMEOUT), .DUMMY_WORD(DUMMY_WORD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .m_cyc_i(m_cyc_i), .m_stb_i(m_stb_i),
  .m_dat_o(m_dat_o), .m_ack_o(m_ack_o), .m_err_o(m_err_o),
  .s_stb_o(s_stb_o), .s_ack_i(s_ack_i), .s_err_i(s_err_i)
);

// File: tb/tb_dbus_decoder.sv
module tb_dbus_decoder;
  localparam int N = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int TO = 512;
  localparam int VW = 32 + 4 + 4 + 4 + 4 + 1 + 1 + 32;
  localparam int NV = 7;

  // {adr, ack_en, err_en, junk_ack, exp_stb, exp_ack, exp_err, exp_dat}
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'h0000_0004, 4'hF, 4'h0, 4'h0, 4'b0001, 1'b1, 1'b0, 32'h5100_0000}, // R1 R2
    {32'h1000_0100, 4'hF, 4'h0, 4'h0, 4'b0010, 1'b1, 1'b0, 32'h5100_0001}, // R2
    {32'h2000_0010, 4'hF, 4'h0, 4'h0, 4'b0100, 1'b1, 1'b0, 32'h5100_0002}, // R3
    {32'h2500_0000, 4'hF, 4'h0, 4'h0, 4'b1000, 1'b1, 1'b0, 32'h5100_0003}, // R3
    {32'h1000_0000, 4'h0, 4'h0, 4'hD, 4'b0010, 1'b0, 1'b0, 32'h5100_0001}, // R4
    {32'h3000_0000, 4'hF, 4'h0, 4'h0, 4'b0000, 1'b0, 1'b0, 32'h0000_0000}, // R9
    {32'h0000_0008, 4'h0, 4'h1, 4'h0, 4'b0001, 1'b0, 1'b1, 32'h5100_0000}  // R1 R4
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_cyc = 1'b0, m_stb = 1'b0, m_we = 1'b0;
  logic [AW-1:0] m_adr = '0;
  logic [DW-1:0] m_wdat = 32'h1234_5678;
  logic [3:0] m_sel = 4'hF;
  logic [DW-1:0] m_dat, e_dat;
  logic m_ack, m_err, e_ack, e_err;
  logic [N-1:0] s_cyc, s_stb, e_cyc, e_stb;
  logic s_we, e_we;
  logic [AW-1:0] s_adr, e_adr;
  logic [DW-1:0] s_wdat, e_wdat;
  logic [3:0] s_sel, e_sel;
  logic [N*DW-1:0] s_rdat;
  logic [N-1:0] s_ack, s_err;
  logic [N-1:0] ack_en = '0, err_en = '0, junk = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_slv
    assign s_rdat[i*DW +: DW] = 32'h5100_0000 | i;
  end
  assign s_ack = (s_stb & ack_en) | junk;
  assign s_err = s_stb & err_en;

  dbus_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we),
    .m_adr_i(m_adr), .m_dat_i(m_wdat), .m_sel_i(m_sel),
    .m_dat_o(m_dat), .m_ack_o(m_ack), .m_err_o(m_err),
    .s_cyc_o(s_cyc), .s_stb_o(s_stb), .s_we_o(s_we), .s_adr_o(s_adr),
    .s_dat_o(s_wdat), .s_sel_o(s_sel),
    .s_dat_i(s_rdat), .s_ack_i(s_ack), .s_err_i(s_err)
  );

  dbus_decoder #(.ACK_ON_TIMEOUT(1'b0)) dut_e (
    .clk_i(clk), .rst_ni(rst_n), .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we),
    .m_adr_i(m_adr), .m_dat_i(m_wdat), .m_sel_i(m_sel),
    .m_dat_o(e_dat), .m_ack_o(e_ack), .m_err_o(e_err),
    .s_cyc_o(e_cyc), .s_stb_o(e_stb), .s_we_o(e_we), .s_adr_o(e_adr),
    .s_dat_o(e_wdat), .s_sel_o(e_sel),
    .s_dat_i('0), .s_ack_i('0), .s_err_i('0)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // hold request until a response on the chosen dut; return cycle count
  task automatic wait_resp(input bit err_dut, output int n);
    n = 1;
    #1;
    while (!(err_dut ? (e_ack || e_err) : (m_ack || m_err)) && n < TO + 8) begin
      @(negedge clk);
      #1;
      n++;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    m_cyc = 0; m_stb = 0; ack_en = '0; err_en = '0; junk = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    // R10: reset state
    m_cyc = 1; m_stb = 0; m_adr = 32'h0;
    #5;
    chk("R10 stb in reset", 64'(s_stb), 0);
    chk("R10 ack/err in reset", {m_ack, m_err, e_ack, e_err}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_cyc = 0;
    @(negedge clk); #1;
    chk("R10 idle after reset", {s_stb, m_ack, m_err}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      @(negedge clk);
      m_adr = e[VW-1 -: 32]; ack_en = e[49:46]; err_en = e[45:42]; junk = e[41:38];
      m_we = v[0]; m_wdat = 32'hA500_0000 | v;
      m_cyc = 1; m_stb = 1;
      #1;
      chk($sformatf("R2 stb v%0d", v), 64'(s_stb), 64'(e[37:34]));
      chk($sformatf("R1 ack v%0d", v), 64'(m_ack), 64'(e[33]));
      chk($sformatf("R4 err v%0d", v), 64'(m_err), 64'(e[32]));
      chk($sformatf("R4 dat v%0d", v), 64'(m_dat), 64'(e[31:0]));
      chk($sformatf("R2 shared v%0d", v), {s_adr, s_wdat}, {m_adr, m_wdat});
      idle();
      #1;
      chk($sformatf("R4 idle junk v%0d", v), {m_ack, m_err}, 0);
    end

    // R5 R6 R9: unmapped write times out with dummy ack
    @(negedge clk);
    m_adr = 32'h3000_0040; m_we = 1; m_cyc = 1; m_stb = 1; ack_en = 4'hF;
    wait_resp(0, n);
    chk("R5 timeout cycle", 64'(n), 64'(TO));
    chk("R6 dummy data", 64'(m_dat), 64'h0000_0000_DEAD_BEEF);
    chk("R6 ack not err", {m_ack, m_err}, 2'b10);
    chk("R9 no strobe", 64'(s_stb), 0);
    @(negedge clk); #1;
    chk("R8 single pulse", {m_ack, m_err}, 0);
    idle();

    // R8: partial wait then drop clears the count
    @(negedge clk);
    m_adr = 32'h3000_0000; m_cyc = 1; m_stb = 1;
    repeat (300) @(negedge clk);
    m_stb = 0;
    @(negedge clk);
    m_stb = 1;
    wait_resp(0, n);
    chk("R8 restart count", 64'(n), 64'(TO));
    idle();

    // R5: mapped but silent slave
    @(negedge clk);
    m_adr = 32'h1000_0010; m_we = 0; m_cyc = 1; m_stb = 1;
    wait_resp(0, n);
    chk("R5 silent slave", 64'(n), 64'(TO));
    chk("R6 silent slave data", 64'(m_dat), 64'h0000_0000_DEAD_BEEF);
    idle();

    // R7: error mode
    @(negedge clk);
    m_adr = 32'h3000_0000; m_cyc = 1; m_stb = 1;
    wait_resp(1, n);
    chk("R7 err cycle", 64'(n), 64'(TO));
    chk("R7 err not ack", {e_ack, e_err}, 2'b01);
    @(negedge clk); #1;
    chk("R8 err pulse", {e_ack, e_err}, 0);
    idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule